// File: doc/BRIEF.md
# Adjacent-Channel Crosstalk Compensator

This block cleans up a pair of neighbouring 8-bit sample streams, A and B, whose analog front ends couple into each other capacitively. A fast edge on one channel leaves a small copy of itself on the other. For every accepted sample pair the block takes the recent change (delta) of each channel, scales it by a programmable fraction of 256, and subtracts it from the other channel's new sample. The result is clamped to the 8-bit range. The aim is a trace that is clean enough for an 8-bit display, not an exact reconstruction.

Each channel keeps its own history of past accepted samples. A tap selector chooses which pair of neighbouring samples forms the delta, so the correction can be lined up in time with the coupling seen at the current sample rate. With sampling on every fourth clock, tap 2 with a scale of 100 is a typical setting. With sampling on every second clock, a scale of 200 suits better. Until the history is full after reset, the deltas count as zero and samples pass through unchanged.

Samples enter and leave on valid/ready streams. An input pair is taken on a clock edge where `in_valid` and `in_ready` are both high. The corrected pair is presented on the following cycle and held until the consumer takes it with `out_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the block keeps full throughput when the consumer never stalls. The tap and scale are plain control pins, read in the cycle the sample pair is taken.

Top module: `xtc_compensator`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A pair is accepted on a rising edge with `in_valid && in_ready`, and its corrected result is presented with `out_valid` high right after that edge.
- R2: While `out_valid` is high and `out_ready` is low, `out_a`, `out_b` and `out_valid` hold their values and no input is accepted.
- R3: Corrected A equals `in_a - ((dB * scale_num + 128) >>> 8)`, where dB is channel B's signed delta and the shift is arithmetic (it rounds toward minus infinity). `scale_num` is unsigned, 0 to 255.
- R4: Corrected B is formed the same way from `in_b` and channel A's delta, with the same `scale_num`.
- R5: With `tap_sel` = k (0 to 3), a channel's delta is s[n-k] - s[n-k-1], where s[n] is the current sample and s[n-j] is the sample accepted j transfers earlier. Only accepted samples enter the history; idle and stalled cycles do not shift it.
- R6: The first 4 pairs accepted after reset use zero deltas, so they leave unchanged.
- R7: A result below 0 becomes 0 and a result above 255 becomes 255.
- R8: `scale_num` = 0 passes both samples through unchanged. `tap_sel` and `scale_num` take effect on the pair accepted in the same cycle.
- R9: A synchronous active-high `rst` clears the history and the output register. After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Block can accept a pair this cycle |
| in_a | input | 8 | New sample, channel A |
| in_b | input | 8 | New sample, channel B |
| tap_sel | input | 2 | Delta tap, samples back from the current one |
| scale_num | input | 8 | Correction scale numerator, over 256 |
| out_valid | output | 1 | Corrected pair valid |
| out_ready | input | 1 | Consumer takes the corrected pair |
| out_a | output | 8 | Corrected sample, channel A |
| out_b | output | 8 | Corrected sample, channel B |

## Verification
A history register that shifts on a stall, or one that misses a shift, does not show at once. It shows on the first output after the selected tap reaches the bad entry. That is up to four accepted pairs later, and only when scale is nonzero and the other channel is moving. A warm-up counter that is off by one shows on the fourth or fifth pair after reset, as a corrected value where a plain copy was expected, or the reverse. The reference model is compared on every clock, and the stimulus mixes idle gaps, consumer stalls, every tap value and steps from rail to rail. Each of these faults therefore reaches the ports within a handful of transfers.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
  // fixed-point scale: numerator over 2**FRAC_BITS
  localparam int FRAC_BITS  = 8;
  localparam int ROUND_BIAS = 1 << (FRAC_BITS - 1);
endpackage

// File: rtl/xtc_history.sv
module xtc_history #(
  parameter int DATA_W = 8,
  parameter int TAP_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_en,
  input  logic [DATA_W-1:0]        cur,
  input  logic [TAP_W-1:0]         tap,
  input  logic                     filled,
  output logic signed [DATA_W:0]   delta
);
  localparam int DEPTH = 1 << TAP_W;

  logic [DATA_W-1:0] hist [DEPTH];
  logic [DATA_W-1:0] seq  [DEPTH+1];
  logic [TAP_W:0]    idx_new, idx_old;

  assign seq[0] = cur;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)           hist[i] <= '0;
        else if (shift_en) hist[i] <= cur;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)           hist[i] <= '0;
        else if (shift_en) hist[i] <= hist[i-1];
      end
    end
    assign seq[i+1] = hist[i];
  end

  assign idx_new = {1'b0, tap};
  assign idx_old = idx_new + 1'b1;

  always_comb begin
    if (filled)
      delta = $signed({1'b0, seq[idx_new]}) - $signed({1'b0, seq[idx_old]});
    else
      delta = '0;
  end

  // R5: with no shift and unchanged inputs, the delta must not move
  assert_stall_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!shift_en) && $stable(cur) && $stable(tap) && $stable(filled)) |-> $stable(delta));
endmodule

// File: rtl/xtc_correct.sv
module xtc_correct #(
  parameter int DATA_W  = 8,
  parameter int SCALE_W = 8
) (
  input  logic [DATA_W-1:0]       sample,
  input  logic signed [DATA_W:0]  other_delta,
  input  logic [SCALE_W-1:0]      scale,
  output logic [DATA_W-1:0]       result
);
  localparam int PROD_W = DATA_W + SCALE_W + 2;
  localparam logic signed [PROD_W-1:0] BIAS  = PROD_W'(xtc_pkg::ROUND_BIAS);
  localparam logic signed [PROD_W:0]   MAX_V = (PROD_W+1)'((1 << DATA_W) - 1);

  logic signed [PROD_W-1:0] d_ext, s_ext, prod, corr;
  logic signed [PROD_W:0]   diff, smp_ext, corr_ext;

  always_comb begin
    d_ext    = PROD_W'(other_delta);
    s_ext    = PROD_W'({1'b0, scale});
    prod     = d_ext * s_ext;
    corr     = (prod + BIAS) >>> xtc_pkg::FRAC_BITS;
    smp_ext  = (PROD_W+1)'({1'b0, sample});
    corr_ext = (PROD_W+1)'(corr);
    diff     = smp_ext - corr_ext;
    if (diff < 0)          result = '0;
    else if (diff > MAX_V) result = '1;
    else                   result = diff[DATA_W-1:0];
  end

  // R3: a rising neighbour can only pull the sample down
  always_comb begin
    if (!$isunknown({other_delta, sample, result}) && other_delta >= 0)
      assert_sign_R3: assert (result <= sample);
  end
endmodule

// File: rtl/xtc_compensator.sv
module xtc_compensator #(
  parameter int DATA_W  = 8,
  parameter int TAP_W   = 2,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_a,
  input  logic [DATA_W-1:0]  in_b,
  input  logic [TAP_W-1:0]   tap_sel,
  input  logic [SCALE_W-1:0] scale_num,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_a,
  output logic [DATA_W-1:0]  out_b
);
  localparam int DEPTH = 1 << TAP_W;
  localparam int CNT_W = TAP_W + 1;

  logic                     accept, filled;
  logic [CNT_W-1:0]         fill_cnt;
  logic [DATA_W-1:0]        smp [2];
  logic signed [DATA_W:0]   dlt [2];
  logic [DATA_W-1:0]        res [2];

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign filled   = (fill_cnt == CNT_W'(DEPTH));
  assign smp[0]   = in_a;
  assign smp[1]   = in_b;

  // warm-up counter: counts accepted pairs until the history is full
  always_ff @(posedge clk) begin
    if (rst)                   fill_cnt <= '0;
    else if (accept && !filled) fill_cnt <= fill_cnt + 1'b1;
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    xtc_history #(.DATA_W(DATA_W), .TAP_W(TAP_W)) hist_i (
      .clk      (clk),
      .rst      (rst),
      .shift_en (accept),
      .cur      (smp[c]),
      .tap      (tap_sel),
      .filled   (filled),
      .delta    (dlt[c])
    );
    xtc_correct #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) corr_i (
      .sample      (smp[c]),
      .other_delta (dlt[1-c]),
      .scale       (scale_num),
      .result      (res[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_a     <= '0;
      out_b     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_a <= res[0];
        out_b <= res[1];
      end
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_a) && $stable(out_b)));

  assert_warmup_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && fill_cnt < CNT_W'(DEPTH)) |=> (out_a == $past(in_a) && out_b == $past(in_b)));

  assert_zero_scale_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && scale_num == '0) |=> (out_a == $past(in_a) && out_b == $past(in_b)));
endmodule

// File: tb/xtc_compensator_tb.sv
module xtc_compensator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_a = '0, in_b = '0, scale_num = '0;
  logic [1:0] tap_sel = '0;
  logic       in_ready, out_valid;
  logic [7:0] out_a, out_b;

  int    n_checks = 0, n_errors = 0, rdy_pct = 100;
  string tag = "R9";
  bit    done = 0;

  // reference model state
  int  qa[$], qb[$];
  bit  m_ov = 0, m_acc = 0;
  int  ea = 0, eb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xtc_compensator dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .tap_sel(tap_sel), .scale_num(scale_num),
    .out_valid(out_valid), .out_ready(out_ready), .out_a(out_a), .out_b(out_b)
  );

  function automatic int pick(int q[$], int cur, int idx);
    return (idx == 0) ? cur : q[idx-1];
  endfunction

  function automatic int fix(int s, int d, int sc);
    int v;
    v = s - ((d * sc + 128) >>> 8);
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  always @(posedge clk) begin
    m_acc = 0;
    if (rst) begin
      m_ov = 0; qa.delete(); qb.delete();
    end else if (in_valid && (!m_ov || out_ready)) begin
      int da, db, k;
      da = 0; db = 0; k = int'(tap_sel);
      if (qa.size() == 4) begin
        da = pick(qa, int'(in_a), k) - pick(qa, int'(in_a), k+1);
        db = pick(qb, int'(in_b), k) - pick(qb, int'(in_b), k+1);
      end
      ea = fix(int'(in_a), db, int'(scale_num));
      eb = fix(int'(in_b), da, int'(scale_num));
      qa.push_front(int'(in_a)); qb.push_front(int'(in_b));
      if (qa.size() > 4) begin void'(qa.pop_back()); void'(qb.pop_back()); end
      m_ov = 1; m_acc = 1;
    end else if (out_ready) begin
      m_ov = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare every cycle, just after the inputs for the cycle are driven
  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      check("R1", "in_ready", int'(in_ready), int'(!m_ov || out_ready));
      check(tag, "out_valid", int'(out_valid), int'(m_ov));
      if (m_ov) begin
        check(tag, "out_a", int'(out_a), ea);
        check(tag, "out_b", int'(out_b), eb);
      end
    end
  end

  task automatic push(int a, int b);
    @(negedge clk);
    in_valid = 1; in_a = 8'(a); in_b = 8'(b);
    out_ready = ($urandom_range(99) < rdy_pct);
    forever begin
      @(posedge clk); #1;
      if (m_acc) break;
      @(negedge clk);
      out_ready = ($urandom_range(99) < rdy_pct);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 0; in_a = 8'($urandom); in_b = 8'($urandom);
      out_ready = ($urandom_range(99) < rdy_pct);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; in_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    #1;
    check("R9", "out_valid after reset", int'(out_valid), 0);
    check("R9", "in_ready after reset", int'(in_ready), 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    do_reset();

    // R6: warm-up pairs pass through despite a large scale
    tag = "R6"; scale_num = 8'd200; tap_sel = 2'd0;
    push(10, 250); push(240, 5); push(0, 128); push(77, 33);

    // R3 / R4: corrected stream, tap 2, scale 100, free-flowing
    tag = "R3"; scale_num = 8'd100; tap_sel = 2'd2;
    for (int i = 0; i < 40; i++) push($urandom_range(255), $urandom_range(255));
    tag = "R4";
    for (int i = 0; i < 20; i++) push(128 + 60*(i%2), (i*37) % 256);

    // R5: every tap with idle gaps in between
    tag = "R5";
    for (int t = 0; t < 4; t++) begin
      tap_sel = 2'(t);
      for (int i = 0; i < 12; i++) begin
        push($urandom_range(255), $urandom_range(255));
        if (i % 3 == 0) idle(2);
      end
    end

    // R2: consumer stalls often
    tag = "R2"; rdy_pct = 35; tap_sel = 2'd1; scale_num = 8'd180;
    for (int i = 0; i < 40; i++) push($urandom_range(255), $urandom_range(255));
    rdy_pct = 100;

    // R7: rail-to-rail steps drive the result past both ends
    tag = "R7"; tap_sel = 2'd0; scale_num = 8'd255;
    for (int i = 0; i < 5; i++) push(0, 0);
    push(0, 255); push(255, 0); push(255, 0); push(0, 255); push(255, 255);

    // R8: zero scale, and scale changing pair by pair
    tag = "R8"; scale_num = 8'd0;
    for (int i = 0; i < 10; i++) push($urandom_range(255), $urandom_range(255));
    for (int i = 0; i < 10; i++) begin
      scale_num = 8'(i * 25);
      push($urandom_range(255), $urandom_range(255));
    end

    // R9 / R6: reset mid-stream clears history, warm-up restarts
    do_reset();
    tag = "R6"; scale_num = 8'd255;
    for (int i = 0; i < 8; i++) push($urandom_range(255), $urandom_range(255));
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule